// File: doc/BRIEF.md
# Eight-Channel Compare/Capture Timer with Access-Triggered Flag Clearing

The block holds a free-running up-counter shared by eight channels. Each channel works either as an output compare or as an input capture. An output-compare channel raises its event flag when the counter reaches the channel's value, and it can toggle, force low or force high its pin. An input-capture channel latches the counter on a rising edge of its capture input and raises its flag. A sticky overflow flag records each wrap of the counter.

Software reaches the block over a simple register bus with separate read and write strobes. The read data is combinational on the address, and only a read strobe has side effects.

Flags normally clear when software writes one to them. A control bit selects an alternative mode in which touching the associated data register clears the flag instead. In that mode, accesses to two pulse-accumulator addresses also produce clear strobes for an accumulator outside the block. Two freeze conditions stop the counter: one tied to the wait input and one tied to the debug input. Each is enabled by its own control bit, and the block tells the neighbouring accumulator and modulus counter which of them must halt.

Top module: `octimer`

## Requirements
- R1: After reset the counter, every control register, the channel flags, the overflow flag and the compare states are 0. With those values, `pin_oe` is 0. Reads of unused addresses (0x09, 0x0A, 0x0B..0x0F, 0x18..0x1F) return 0.
- R2: The counter at address 0x00 increments by one on every clock while it is not frozen. It wraps from 0xFFFF to 0x0000. Bus writes to address 0x00 do not change it.
- R3: The overflow flag (address 0x08, bit 0) becomes 1 on the cycle after the counter advances from 0xFFFF. In normal mode, a write with bit 0 set clears it, and a write with bit 0 clear leaves it.
- R4: A channel n whose bit is 1 in the mode register (0x06) is an output compare. On the cycle after a non-frozen cycle in which the counter equals its data register (0x10+n), its flag (0x07 bit n) sets. In the same cycle its compare state takes the action held in bits [2n+1:2n] of the action register (0x02): 00 leaves it unchanged, 01 toggles it, 10 clears it, 11 sets it.
- R5: When channel n's action field is non-zero, `pin_oe[n]` is 1 and `pin_out[n]` carries the compare state, whatever the direction register (0x04) holds. Otherwise `pin_oe[n]` follows direction bit n and `pin_out[n]` follows port data bit n (0x05).
- R6: With bit n of the mask register (0x03) set, a compare match still sets channel n's flag but leaves its compare state unchanged.
- R7: A channel whose mode bit is 0 is an input capture. A cycle in which `cap_in[n]` is 1 after being 0 in the previous cycle copies that cycle's counter value into data register n and sets flag n on the next cycle. A capture takes priority over a bus write to the same register.
- R8: In normal mode (control 0x01 bit 0 = 0), writing to 0x07 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0. A flag set event in the same cycle as its clear leaves the flag set.
- R9: In fast mode (control bit 0 = 1), writes to 0x07 and 0x08 have no effect on the flags. A read strobe on an input-capture channel's data register, or a write strobe on an output-compare channel's data register, clears that channel's flag. A set event in the same cycle still wins.
- R10: In fast mode, a read or a write strobe at address 0x00 clears the overflow flag.
- R11: In fast mode, a read or a write strobe at 0x09 drives `pa_clr_a` high in that same cycle, and one at 0x0A drives `pa_clr_b` high. In normal mode both stay 0.
- R12: The counter and all compare matches freeze while control bit 1 is set and `wait_in` is 1, and also while control bit 2 is set and `dbg_in` is 1. `halt_mod` is high in either case. `halt_pa` is high only in the wait case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr | input | 1 | Bus write strobe |
| rd | input | 1 | Bus read strobe (side effects only) |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| cap_in | input | 8 | Capture inputs, one per channel |
| wait_in | input | 1 | Wait-mode indication |
| dbg_in | input | 1 | Debug-mode indication |
| rdata | output | 16 | Read data for `addr` |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| pa_clr_a | output | 1 | Clear strobe for accumulator A flags |
| pa_clr_b | output | 1 | Clear strobe for accumulator B flags |
| halt_pa | output | 1 | Halt request to the pulse accumulators |
| halt_mod | output | 1 | Halt request to the modulus counter |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as the set event for that flag. The stimulus reaches it by taking the live counter value from the reference model, programming a compare value a few counts ahead, and idling until the model's counter equals that value. It then issues the clear in exactly that cycle, once as a one-written to the flag register and once as a data-register write in fast mode. Overflow behaviour needs the counter to cross 0xFFFF, so the bench waits out two full wraps. It clears the overflow flag once per clearing mode, and it writes the counter at the wrap to show that the write is ignored.

// File: rtl/octimer.sv
module octimer #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic           rd,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  input  logic [NCH-1:0] cap_in,
  input  logic           wait_in,
  input  logic           dbg_in,
  output logic [CW-1:0]  rdata,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe,
  output logic           pa_clr_a,
  output logic           pa_clr_b,
  output logic           halt_pa,
  output logic           halt_mod
);
  localparam logic [AW-1:0] A_CNT  = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_ACT  = AW'(2);
  localparam logic [AW-1:0] A_MASK = AW'(3);
  localparam logic [AW-1:0] A_DIR  = AW'(4);
  localparam logic [AW-1:0] A_PORT = AW'(5);
  localparam logic [AW-1:0] A_SEL  = AW'(6);
  localparam logic [AW-1:0] A_FLG  = AW'(7);
  localparam logic [AW-1:0] A_OVF  = AW'(8);
  localparam logic [AW-1:0] A_PAA  = AW'(9);
  localparam logic [AW-1:0] A_PAB  = AW'(10);
  localparam int            DBASE  = 16;

  logic [CW-1:0]    cnt;
  logic [2:0]       ctrl;
  logic [2*NCH-1:0] act;
  logic [NCH-1:0]   mask, dir, port, sel, flag, st, cap_q;
  logic             ovf;
  logic [CW-1:0]    data [NCH];
  logic [NCH-1:0]   hit, rise, fset, fclr, dsel;
  logic             fast, run, ovf_clr;

  assign fast     = ctrl[0];
  assign halt_pa  = ctrl[1] & wait_in;
  assign halt_mod = halt_pa | (ctrl[2] & dbg_in);
  assign run      = ~halt_mod;
  assign pa_clr_a = fast & (rd | wr) & (addr == A_PAA);
  assign pa_clr_b = fast & (rd | wr) & (addr == A_PAB);
  assign ovf_clr  = fast ? ((rd | wr) & (addr == A_CNT))
                         : (wr & (addr == A_OVF) & wdata[0]);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      dsel[i] = (addr == AW'(DBASE + i));
      hit[i]  = sel[i] & run & (cnt == data[i]);
      rise[i] = ~sel[i] & cap_in[i] & ~cap_q[i];
      fset[i] = hit[i] | rise[i];
      fclr[i] = fast ? (dsel[i] & (sel[i] ? wr : rd))
                     : (wr & (addr == A_FLG) & wdata[i]);
      pin_oe[i]  = (|act[2*i +: 2]) | dir[i];
      pin_out[i] = (|act[2*i +: 2]) ? st[i] : port[i];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CNT:  rdata = cnt;
      A_CTRL: rdata = CW'(ctrl);
      A_ACT:  rdata = CW'(act);
      A_MASK: rdata = CW'(mask);
      A_DIR:  rdata = CW'(dir);
      A_PORT: rdata = CW'(port);
      A_SEL:  rdata = CW'(sel);
      A_FLG:  rdata = CW'(flag);
      A_OVF:  rdata = CW'(ovf);
      default: begin
        for (int i = 0; i < NCH; i++)
          if (dsel[i]) rdata = data[i];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ctrl <= '0; act <= '0; mask <= '0; dir <= '0;
      port <= '0; sel <= '0; flag <= '0; st <= '0; cap_q <= '0; ovf <= 1'b0;
      for (int i = 0; i < NCH; i++) data[i] <= '0;
    end else begin
      if (run) cnt <= cnt + 1'b1;
      if (wr) begin
        case (addr)
          A_CTRL: ctrl <= wdata[2:0];
          A_ACT:  act  <= wdata[2*NCH-1:0];
          A_MASK: mask <= wdata[NCH-1:0];
          A_DIR:  dir  <= wdata[NCH-1:0];
          A_PORT: port <= wdata[NCH-1:0];
          A_SEL:  sel  <= wdata[NCH-1:0];
          default: ;
        endcase
      end
      ovf   <= (run & (&cnt)) | (ovf & ~ovf_clr);
      flag  <= fset | (flag & ~fclr);
      cap_q <= cap_in;
      for (int i = 0; i < NCH; i++) begin
        if (wr && dsel[i]) data[i] <= wdata;
        if (rise[i])       data[i] <= cnt;
        if (hit[i] && !mask[i]) begin
          case (act[2*i +: 2])
            2'b01:   st[i] <= ~st[i];
            2'b10:   st[i] <= 1'b0;
            2'b11:   st[i] <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module octimer_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd,
  input logic           wr,
  input logic [AW-1:0]  addr,
  input logic [CW-1:0]  cnt,
  input logic           ovf,
  input logic [NCH-1:0] flag,
  input logic           fast,
  input logic           run,
  input logic           wait_in,
  input logic           dbg_in,
  input logic           halt_pa
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + 1'b1);
  // R12
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (&cnt)) |=> ovf);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr) |=> ((flag & $past(flag)) == $past(flag)));
  // R9
  fast_w1c_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast && wr && addr == AW'(7)) |=> ((flag & $past(flag)) == $past(flag)));
  // R12
  pa_run_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_in && !wait_in) |-> !halt_pa);
endmodule

bind octimer octimer_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr), .addr(addr), .cnt(cnt),
  .ovf(ovf), .flag(flag), .fast(fast), .run(run), .wait_in(wait_in),
  .dbg_in(dbg_in), .halt_pa(halt_pa)
);

// File: tb/octimer_tb.sv
module octimer_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0, wait_in = 1'b0, dbg_in = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  cap_in = '0;
  logic [15:0] rdata;
  logic [7:0]  pin_out, pin_oe;
  logic        pa_clr_a, pa_clr_b, halt_pa, halt_mod;

  octimer u_dut (.clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
    .cap_in(cap_in), .wait_in(wait_in), .dbg_in(dbg_in), .rdata(rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .pa_clr_a(pa_clr_a), .pa_clr_b(pa_clr_b), .halt_pa(halt_pa),
    .halt_mod(halt_mod));

  always #2 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic [15:0] m_cnt, m_act;
  logic [2:0]  m_ctrl;
  logic [7:0]  m_mask, m_dir, m_port, m_sel, m_flag, m_st, m_capq;
  logic        m_ovf;
  logic [15:0] m_data [8];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] e_rd(logic [4:0] a);
    case (a)
      5'd0: return m_cnt;
      5'd1: return {13'd0, m_ctrl};
      5'd2: return m_act;
      5'd3: return {8'd0, m_mask};
      5'd4: return {8'd0, m_dir};
      5'd5: return {8'd0, m_port};
      5'd6: return {8'd0, m_sel};
      5'd7: return {8'd0, m_flag};
      5'd8: return {15'd0, m_ovf};
      default: return (a >= 16 && a < 24) ? m_data[a-16] : 16'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    if (a == 0) return "R2";
    if (a == 7) return "R8";
    if (a == 8) return "R3";
    if (a >= 16) return "R4";
    return "R1";
  endfunction

  // reference model: behavioural next-state per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_ctrl = 0; m_mask = 0; m_dir = 0; m_port = 0;
      m_sel = 0; m_flag = 0; m_st = 0; m_capq = 0; m_ovf = 0;
      for (int i = 0; i < 8; i++) m_data[i] = 0;
    end else begin
      bit run, fast;
      logic [7:0] nf, ns;
      logic [15:0] nd [8];
      logic nov;
      run  = !((m_ctrl[1] && wait_in) || (m_ctrl[2] && dbg_in));
      fast = m_ctrl[0];
      nf = m_flag; ns = m_st; nov = m_ovf;
      for (int i = 0; i < 8; i++) nd[i] = m_data[i];
      if (!fast && wr && addr == 7) nf = nf & ~wdata[7:0];
      if (!fast && wr && addr == 8 && wdata[0]) nov = 0;
      if (fast && (rd || wr) && addr == 0) nov = 0;
      for (int i = 0; i < 8; i++) begin
        if (fast && addr == 16 + i && ((rd && !m_sel[i]) || (wr && m_sel[i]))) nf[i] = 0;
        if (wr && addr == 16 + i) nd[i] = wdata;
        if (m_sel[i] && run && m_cnt == m_data[i]) begin
          nf[i] = 1;
          if (!m_mask[i]) begin
            if (m_act[2*i +: 2] == 2'b01) ns[i] = ~m_st[i];
            else if (m_act[2*i +: 2] == 2'b10) ns[i] = 0;
            else if (m_act[2*i +: 2] == 2'b11) ns[i] = 1;
          end
        end
        if (!m_sel[i] && cap_in[i] && !m_capq[i]) begin
          nd[i] = m_cnt; nf[i] = 1;
        end
      end
      if (run && m_cnt == 16'hFFFF) nov = 1;
      if (wr) case (addr)
        5'd1: m_ctrl = wdata[2:0];
        5'd2: m_act  = wdata;
        5'd3: m_mask = wdata[7:0];
        5'd4: m_dir  = wdata[7:0];
        5'd5: m_port = wdata[7:0];
        5'd6: m_sel  = wdata[7:0];
        default: ;
      endcase
      if (run) m_cnt = m_cnt + 1;
      m_flag = nf; m_st = ns; m_ovf = nov; m_capq = cap_in;
      for (int i = 0; i < 8; i++) m_data[i] = nd[i];
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] own, eo, ee;
      bit fast;
      for (int i = 0; i < 8; i++) own[i] = |m_act[2*i +: 2];
      eo = (own & m_st) | (~own & m_port);
      ee = own | m_dir;
      fast = m_ctrl[0];
      chk(tag_of(addr), rdata, e_rd(addr));
      chk("R5 pin_out", pin_out, eo);
      chk("R5 pin_oe", pin_oe, ee);
      chk("R11 strobes", {pa_clr_a, pa_clr_b},
          {fast && (rd || wr) && addr == 9, fast && (rd || wr) && addr == 10});
      chk("R12 halts", {halt_pa, halt_mod},
          {m_ctrl[1] && wait_in, (m_ctrl[1] && wait_in) || (m_ctrl[2] && dbg_in)});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wreg(logic [4:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1; tick(); wr = 0;
  endtask
  task automatic rreg(logic [4:0] a);
    addr = a; rd = 1; tick(); rd = 0;
  endtask
  task automatic peek(string tag, logic [4:0] a, logic [15:0] exp);
    addr = a; @(negedge clk); chk(tag, rdata, exp); @(posedge clk); #1;
  endtask

  initial begin
    logic [15:0] tgt, capv;
    tick(3); rst_n = 1; tick();
    // R1 reset values
    for (int a = 1; a < 16; a++) peek("R1 reset", a[4:0], 16'd0);
    chk("R1 pin_oe", pin_oe, 8'h00);
    // R5 direction/port path
    wreg(4, 16'h000F); wreg(5, 16'h0005);
    @(negedge clk); chk("R5 dir oe", pin_oe, 8'h0F); chk("R5 port", pin_out, 8'h05);
    tick();
    // R4 compare actions, R6 mask
    wreg(6, 16'h001F); wreg(2, 16'h0139); wreg(3, 16'h0010);
    for (int i = 0; i < 5; i++) wreg(5'(16 + i), m_cnt + 16'(30 + 4 * i));
    tick(80);
    peek("R4 flags", 7, 16'h001F);
    chk("R4 pins", pin_out, 8'h05); chk("R6 masked oe", pin_oe, 8'h1F);
    // R8 normal clear
    wreg(7, 16'h0003); peek("R8 w1c", 7, 16'h001C);
    wreg(7, 16'h0000); peek("R8 w0", 7, 16'h001C);
    // R8 set wins over clear
    tgt = m_cnt + 16'd12; wreg(16, tgt);
    while (m_cnt != tgt) tick();
    wreg(7, 16'h0001); peek("R8 set wins", 7, 16'h001D);
    // R7 capture on channel 5
    wreg(6, 16'h001F);
    cap_in[5] = 1; capv = m_cnt; tick(); cap_in[5] = 0; tick(2);
    peek("R7 capture value", 21, capv);
    peek("R7 capture flag", 7, 16'h003D);
    // R9 fast mode clears
    wreg(1, 16'h0001);
    wreg(7, 16'h00FF); peek("R9 w1c ignored", 7, 16'h003D);
    rreg(21); peek("R9 IC read clears", 7, 16'h001D);
    wreg(16, 16'h0100); peek("R9 OC write clears", 7, 16'h001C);
    rreg(17); peek("R9 OC read keeps", 7, 16'h001C);
    // R9 set wins in fast mode
    tgt = m_cnt + 16'd10; wreg(18, tgt);
    while (m_cnt != tgt) tick();
    wreg(18, 16'h0200); peek("R9 set wins", 7, 16'h001C);
    // R11 accumulator strobes
    addr = 9; rd = 1; @(negedge clk); chk("R11 pa_a", pa_clr_a, 1'b1); tick(); rd = 0;
    addr = 10; wr = 1; @(negedge clk); chk("R11 pa_b", pa_clr_b, 1'b1); tick(); wr = 0;
    // R3 overflow and R10 fast counter access clear
    while (m_cnt != 16'hFFFF) tick();
    tick(2); peek("R3 ovf set", 8, 16'h0001);
    wreg(0, 16'h1234); peek("R10 cnt write clears ovf", 8, 16'h0000);
    chk("R2 cnt write ignored", m_cnt < 16'h0100, 1'b1);
    wreg(1, 16'h0000);
    addr = 9; rd = 1; @(negedge clk); chk("R11 normal no strobe", pa_clr_a, 1'b0); tick(); rd = 0;
    while (m_cnt != 16'hFFFF) tick();
    tick(2); peek("R3 ovf again", 8, 16'h0001);
    wreg(8, 16'h0000); peek("R3 w0 keeps", 8, 16'h0001);
    wreg(8, 16'h0001); peek("R3 w1 clears", 8, 16'h0000);
    // R12 freezes
    wreg(1, 16'h0002); wait_in = 1; tick(); capv = m_cnt;
    tick(8); peek("R12 wait freeze", 0, capv); chk("R12 halt_pa", halt_pa, 1'b1);
    wait_in = 0; wreg(1, 16'h0004); dbg_in = 1; tick(); capv = m_cnt;
    tick(8); peek("R12 dbg freeze", 0, capv);
    chk("R12 dbg pa runs", halt_pa, 1'b0); chk("R12 dbg mod halt", halt_mod, 1'b1);
    wreg(1, 16'h0000); tick(4);
    chk("R12 resumes", m_cnt != capv, 1'b1);
    dbg_in = 0; tick(4);
    finish_run();
  end
endmodule